// File: doc/BRIEF.md
# Dual-Channel Windowed PLL Lock Detector

This block decides, for each of two PLL channels, whether the loop is in lock. Each channel supplies its phase-error pulse and a strobe that marks the end of each comparison cycle. The block counts how many sampling-clock periods the error pulse was high during the comparison cycle. A single wide error drops the channel's lock flag at once. The flag is raised again only after a run of consecutive narrow-error comparison cycles. Channel A is the fractional channel and needs a run of 10. Channel B is the integer channel and needs a run of 3.

The two flags merge into one combined lock output. A channel in power-save counts as locked for that output. A three-bit select can instead route the divided reference or the divided feedback of either channel to the monitor output, so the comparator inputs can be observed on one pin. The phase-error pulses come from an external phase detector. The unlock and lock widths are parameters counted in sampling-clock periods.

Top module: `pll_lock_monitor`

## Requirements
- R1: During reset and in the first cycle after it, a_locked, b_locked, lock_all and mon_out are all low.
- R2: A measured width that reaches or exceeds the channel's unlock threshold clears the lock flag and the run counter. The defaults are 2 counts for A and 4 counts for B. The flag updates on the clock edge that samples the strobe.
- R3: Channel A raises its flag on the 10th consecutive in-window comparison cycle, and not on the 9th. A cycle is in-window when its width is below the unlock threshold and no more than the lock threshold (default 4).
- R4: Channel B raises its flag on the 3rd consecutive in-window comparison cycle (default lock threshold 8), and not on the 2nd.
- R5: The measured width is the number of sampling cycles with the error input high since the previous accepted strobe, the strobe cycle included. A narrow pulse below the unlock threshold keeps an existing lock.
- R6: One out-of-window comparison cycle sets the run count back to zero. A full new run is then needed before the flag rises again. Flags change only on cycles where a strobe is accepted.
- R7: While a channel's power-save input is high, its strobes are ignored, its lock flag and run count are held, and its width count is cleared.
- R8: lock_all is registered. It goes high one cycle after each channel is either locked or in power-save, and is low otherwise.
- R9: mon_out is registered with one cycle of latency. With mon_sel[2]=0 it shows the combined lock value. With mon_sel[2]=1, mon_sel[1]=1 picks channel A and 0 picks channel B, and mon_sel[0]=1 picks the divided feedback and 0 picks the divided reference.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| a_phase_err | input | 1 | Channel A phase-error pulse, high while the error lasts |
| a_cmp_strobe | input | 1 | Channel A end-of-comparison-cycle strobe |
| a_pwr_save | input | 1 | Channel A power-save |
| a_ref_div | input | 1 | Channel A divided reference |
| a_fb_div | input | 1 | Channel A divided feedback |
| b_phase_err | input | 1 | Channel B phase-error pulse |
| b_cmp_strobe | input | 1 | Channel B end-of-comparison-cycle strobe |
| b_pwr_save | input | 1 | Channel B power-save |
| b_ref_div | input | 1 | Channel B divided reference |
| b_fb_div | input | 1 | Channel B divided feedback |
| mon_sel | input | 3 | Monitor select: [2] source class, [1] channel, [0] feedback/reference |
| a_locked | output | 1 | Channel A lock flag |
| b_locked | output | 1 | Channel B lock flag |
| lock_all | output | 1 | Combined lock (locked or power-save on both channels) |
| mon_out | output | 1 | Monitor output |

## Verification
The lock logic is driven with directed runs of error widths. These are long zero-width runs that separate the 9th comparison cycle from the 10th and the 2nd from the 3rd, single widths just below and at each unlock threshold, and a wide cycle in the middle of a run, which shows whether the run counter truly restarts. A randomized stream follows, mostly narrow widths with occasional wide ones and power-save windows. It exercises how hold, relock and the combined output interact, and a bench model tracks the expected state. Every monitor code is then swept over all 16 patterns of the four divided clocks, so a swapped channel or a swapped reference/feedback choice shows up as a mismatch.

// File: rtl/pll_lock_pkg.sv
package pll_lock_pkg;

  typedef struct packed {
    logic show_clk;
    logic pick_a;
    logic pick_fb;
  } mon_sel_t;

  function automatic int meter_bits(input int unlock_cnt);
    return $clog2(unlock_cnt + 1) + 1;
  endfunction

  function automatic int run_bits(input int need);
    return $clog2(need + 1) + 1;
  endfunction

endpackage

// File: rtl/lock_width_meter.sv
module lock_width_meter #(
  parameter int UNLOCK_CNT = 2,
  parameter int CW         = pll_lock_pkg::meter_bits(UNLOCK_CNT)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          phase_err,
  input  logic          cmp_strobe,
  input  logic          pwr_save,
  output logic [CW-1:0] width,
  output logic          meas_valid
);

  logic [CW-1:0] acc;

  always_comb begin
    width      = acc + CW'(phase_err);
    meas_valid = cmp_strobe && !pwr_save;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
    end else if (pwr_save || cmp_strobe) begin
      acc <= '0;
    end else if (phase_err && (32'(acc) < UNLOCK_CNT)) begin
      acc <= acc + 1'b1;
    end
  end

  assert_ps_clears_R7: assert property (@(posedge clk) disable iff (rst)
    pwr_save |=> (acc == '0));

  assert_acc_bound_R5: assert property (@(posedge clk) disable iff (rst)
    32'(acc) <= UNLOCK_CNT);

endmodule

// File: rtl/lock_qualifier.sv
module lock_qualifier #(
  parameter int UNLOCK_CNT = 2,
  parameter int LOCK_CNT   = 4,
  parameter int NEED       = 10,
  parameter int CW         = pll_lock_pkg::meter_bits(UNLOCK_CNT)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] width,
  input  logic          meas_valid,
  output logic          locked
);

  localparam int SW = pll_lock_pkg::run_bits(NEED);

  logic [SW-1:0] run;
  logic          too_wide;
  logic          in_window;

  always_comb begin
    too_wide  = 32'(width) >= UNLOCK_CNT;
    in_window = !too_wide && (32'(width) <= LOCK_CNT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run    <= '0;
      locked <= 1'b0;
    end else if (meas_valid) begin
      if (too_wide) begin
        run    <= '0;
        locked <= 1'b0;
      end else if (in_window) begin
        if (32'(run) < NEED) run <= run + 1'b1;
        if (32'(run) + 1 >= NEED) locked <= 1'b1;
      end else begin
        run <= '0;
      end
    end
  end

  // R6: the flag moves only on an accepted strobe
  assert_rise_on_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(meas_valid));

  assert_fall_on_wide_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> $past(meas_valid && (32'(width) >= UNLOCK_CNT)));

  assert_run_cap_R3: assert property (@(posedge clk) disable iff (rst)
    32'(run) <= NEED);

  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !meas_valid |=> $stable(locked));

endmodule

// File: rtl/lock_monitor_mux.sv
module lock_monitor_mux (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] ch_locked,
  input  logic [1:0] ch_pwr_save,
  input  logic [1:0] ch_ref,
  input  logic [1:0] ch_fb,
  input  logic [2:0] sel,
  output logic       lock_all,
  output logic       mon_out
);
  import pll_lock_pkg::*;

  mon_sel_t s;
  logic     all_ok;
  logic     clk_pick;
  logic     ch_idx;

  always_comb begin
    s        = mon_sel_t'(sel);
    all_ok   = &(ch_locked | ch_pwr_save);
    ch_idx   = s.pick_a ? 1'b0 : 1'b1;
    clk_pick = s.pick_fb ? ch_fb[ch_idx] : ch_ref[ch_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_all <= 1'b0;
      mon_out  <= 1'b0;
    end else begin
      lock_all <= all_ok;
      mon_out  <= s.show_clk ? clk_pick : all_ok;
    end
  end

  assert_all_low_R8: assert property (@(posedge clk) disable iff (rst)
    (!ch_locked[0] && !ch_pwr_save[0]) |=> !lock_all);

  assert_all_high_R8: assert property (@(posedge clk) disable iff (rst)
    (ch_locked == 2'b11) |=> lock_all);

  assert_ref_b_R9: assert property (@(posedge clk) disable iff (rst)
    (sel == 3'b100) |=> (mon_out == $past(ch_ref[1])));

  assert_fb_a_R9: assert property (@(posedge clk) disable iff (rst)
    (sel == 3'b111) |=> (mon_out == $past(ch_fb[0])));

endmodule

// File: rtl/pll_lock_monitor.sv
module pll_lock_monitor #(
  parameter int A_UNLOCK_CNT = 2,
  parameter int A_LOCK_CNT   = 4,
  parameter int A_NEED       = 10,
  parameter int B_UNLOCK_CNT = 4,
  parameter int B_LOCK_CNT   = 8,
  parameter int B_NEED       = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       a_phase_err,
  input  logic       a_cmp_strobe,
  input  logic       a_pwr_save,
  input  logic       a_ref_div,
  input  logic       a_fb_div,
  input  logic       b_phase_err,
  input  logic       b_cmp_strobe,
  input  logic       b_pwr_save,
  input  logic       b_ref_div,
  input  logic       b_fb_div,
  input  logic [2:0] mon_sel,
  output logic       a_locked,
  output logic       b_locked,
  output logic       lock_all,
  output logic       mon_out
);

  localparam int NCH = 2;

  logic [NCH-1:0] err_v, strb_v, ps_v, ref_v, fb_v, lk_v;

  assign err_v  = {b_phase_err, a_phase_err};
  assign strb_v = {b_cmp_strobe, a_cmp_strobe};
  assign ps_v   = {b_pwr_save, a_pwr_save};
  assign ref_v  = {b_ref_div, a_ref_div};
  assign fb_v   = {b_fb_div, a_fb_div};

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int UL = (c == 0) ? A_UNLOCK_CNT : B_UNLOCK_CNT;
    localparam int LK = (c == 0) ? A_LOCK_CNT   : B_LOCK_CNT;
    localparam int ND = (c == 0) ? A_NEED       : B_NEED;
    localparam int CW = pll_lock_pkg::meter_bits(UL);

    logic [CW-1:0] width;
    logic          meas_valid;

    lock_width_meter #(.UNLOCK_CNT(UL), .CW(CW)) u_meter (
      .clk        (clk),
      .rst        (rst),
      .phase_err  (err_v[c]),
      .cmp_strobe (strb_v[c]),
      .pwr_save   (ps_v[c]),
      .width      (width),
      .meas_valid (meas_valid)
    );

    lock_qualifier #(.UNLOCK_CNT(UL), .LOCK_CNT(LK), .NEED(ND), .CW(CW)) u_qual (
      .clk        (clk),
      .rst        (rst),
      .width      (width),
      .meas_valid (meas_valid),
      .locked     (lk_v[c])
    );
  end

  lock_monitor_mux u_mux (
    .clk         (clk),
    .rst         (rst),
    .ch_locked   (lk_v),
    .ch_pwr_save (ps_v),
    .ch_ref      (ref_v),
    .ch_fb       (fb_v),
    .sel         (mon_sel),
    .lock_all    (lock_all),
    .mon_out     (mon_out)
  );

  assign a_locked = lk_v[0];
  assign b_locked = lk_v[1];

  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (!a_locked && !b_locked && !lock_all && !mon_out));

endmodule

// File: tb/pll_lock_monitor_test.sv
module pll_lock_monitor_test;

  localparam int CLK_PERIOD = 10;
  localparam int WIN = 12;
  localparam int A_UL = 2, A_LK = 4, A_ND = 10;
  localparam int B_UL = 4, B_LK = 8, B_ND = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a_err = 0, a_strb = 0, a_ps = 0, a_ref = 0, a_fb = 0;
  logic b_err = 0, b_strb = 0, b_ps = 0, b_ref = 0, b_fb = 0;
  logic [2:0] sel = 3'b000;
  logic a_lk, b_lk, lk_all, mon;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  int ma_st = 0, mb_st = 0;
  bit ma_lk = 0, mb_lk = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_lock_monitor uut (
    .clk(clk), .rst(rst),
    .a_phase_err(a_err), .a_cmp_strobe(a_strb), .a_pwr_save(a_ps),
    .a_ref_div(a_ref), .a_fb_div(a_fb),
    .b_phase_err(b_err), .b_cmp_strobe(b_strb), .b_pwr_save(b_ps),
    .b_ref_div(b_ref), .b_fb_div(b_fb),
    .mon_sel(sel),
    .a_locked(a_lk), .b_locked(b_lk), .lock_all(lk_all), .mon_out(mon)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // model of one channel from the requirements
  task automatic model_step(input int w, input bit ps, input int ul, input int lkw,
                            input int need, inout int st, inout bit lk);
    if (ps) return;
    if (w >= ul) begin
      st = 0; lk = 0;
    end else if (w <= lkw) begin
      if (st < need) st = st + 1;
      if (st >= need) lk = 1;
    end else begin
      st = 0;
    end
  endtask

  function automatic logic mon_expect(input logic [2:0] s, input logic all,
                                      input logic ar, input logic af,
                                      input logic br, input logic bf);
    if (!s[2]) return all;
    if (s[1]) return s[0] ? af : ar;
    return s[0] ? bf : br;
  endfunction

  // one comparison cycle on both channels, then flag and combined checks
  task automatic window(input int wa, input int wb, input bit psa, input bit psb,
                        input string tag);
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk);
      a_ps = psa; b_ps = psb;
      a_err = (i < wa); b_err = (i < wb);
      a_strb = (i == WIN-1); b_strb = (i == WIN-1);
    end
    @(negedge clk);
    a_err = 0; b_err = 0; a_strb = 0; b_strb = 0;
    model_step(wa, psa, A_UL, A_LK, A_ND, ma_st, ma_lk);
    model_step(wb, psb, B_UL, B_LK, B_ND, mb_st, mb_lk);
    chk({tag, " a_locked"}, a_lk, ma_lk);
    chk({tag, " b_locked"}, b_lk, mb_lk);
    @(negedge clk);
    chk("R8 lock_all", lk_all, (ma_lk | psa) & (mb_lk | psb));
    chk("R9 mon_out shows lock", mon, (ma_lk | psa) & (mb_lk | psb));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 a_locked in reset", a_lk, 1'b0);
    chk("R1 lock_all in reset", lk_all, 1'b0);
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 a_locked after reset", a_lk, 1'b0);
    chk("R1 b_locked after reset", b_lk, 1'b0);
    chk("R1 mon_out after reset", mon, 1'b0);

    // R4 then R3: clean runs
    window(0, 0, 0, 0, "R4 run1");
    window(0, 3, 0, 0, "R4 run2");
    window(1, 0, 0, 0, "R4 run3 locks");
    for (int k = 4; k <= 9; k++) window(0, 0, 0, 0, "R3 run<10");
    chk("R3 A not locked at 9", a_lk, 1'b0);
    window(0, 0, 0, 0, "R3 run10");
    chk("R3 A locked at 10", a_lk, 1'b1);

    // R5 narrow pulses keep lock; R2 boundary
    window(1, 3, 0, 0, "R5 narrow");
    chk("R5 A kept", a_lk, 1'b1);
    window(2, 4, 0, 0, "R2 at threshold");
    chk("R2 A dropped", a_lk, 1'b0);
    chk("R2 B dropped", b_lk, 1'b0);

    // R6 run restart
    for (int k = 0; k < 5; k++) window(0, 0, 0, 0, "R6 pre");
    window(3, 0, 0, 0, "R6 bad");
    for (int k = 0; k < 9; k++) window(0, 0, 0, 0, "R6 rerun");
    chk("R6 A still unlocked", a_lk, 1'b0);
    window(0, 0, 0, 0, "R6 rerun10");
    chk("R6 A relocked", a_lk, 1'b1);

    // R7 power-save holds, R8 counts as locked
    window(9, 0, 1, 0, "R7 ps wide");
    chk("R7 A held", a_lk, 1'b1);
    window(0, 9, 0, 1, "R7 ps B");
    window(5, 0, 0, 1, "R8 A unlocks");
    window(0, 0, 1, 1, "R8 both ps");

    // R9 monitor sweep
    for (int c = 0; c < 4; c++) begin
      for (int p = 0; p < 16; p++) begin
        @(negedge clk);
        sel = {1'b1, 2'(c)};
        {a_ref, a_fb, b_ref, b_fb} = 4'(p);
        @(negedge clk);
        chk("R9 monitor", mon, mon_expect(sel, 1'b0, a_ref, a_fb, b_ref, b_fb));
      end
    end
    @(negedge clk);
    sel = 3'b000;
    a_ps = 0; b_ps = 0;

    // randomized windows
    for (int n = 0; n < 300; n++) begin
      int wa, wb;
      bit pa, pb;
      wa = ($urandom % 10 < 7) ? int'($urandom % 2) : int'($urandom % 9);
      wb = ($urandom % 10 < 7) ? int'($urandom % 4) : int'($urandom % 10);
      pa = ($urandom % 10 == 0);
      pb = ($urandom % 10 == 0);
      window(wa, wb, pa, pb, "R5 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule